// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This unit executes one class of integer instruction: a 32 by 32 bit multiply that yields a full 64-bit product. An optional 64-bit addend can be added to that product. The caller presents the instruction word, the two operand values and the current contents of the destination register pair as the addend. It also presents the four condition flags and a precomputed bit that says whether the instruction's condition holds. All of these are sampled with a single-cycle start pulse.

The product is formed by an iterative shift-and-add engine that retires STEP_W multiplier bits per cycle. Signed operation works on operand magnitudes and negates the product at the end. A fixed number of cycles after start, a one-cycle done pulse returns the result as a high word and a low word, the two destination register indices and a write-enable pulse. When the instruction asks for it, the pulse also carries updated negative and zero flags. Outputs hold their values until the next done pulse.

Top module: `lmac_unit`

## Requirements
- R1: With instruction bit 22 at 0, the operands are unsigned and {res_hi_o,res_lo_o} is their 64-bit product. Bits 63:32 appear on res_hi_o and bits 31:0 on res_lo_o.
- R2: With instruction bit 22 at 1, the operands are two's-complement signed and {res_hi_o,res_lo_o} is their signed 64-bit product.
- R3: With instruction bit 21 at 1, the 64-bit value {acc_hi_i,acc_lo_i} is added to the product, modulo 2^64, with no overflow indication. With bit 21 at 0, nothing is added.
- R4: hi_idx_o carries instruction bits 19:16 and lo_idx_o carries instruction bits 15:12. The operand fields are bits 11:8 and 3:0.
- R5: wr_en_o pulses together with done_o only when cond_pass_i was 1 at start and the instruction is legal. Otherwise it stays 0.
- R6: flags_i and flags_o are ordered N,Z,C,V from bit 3 down to bit 0. If instruction bit 20 is 1 and the write commits, flags_wr_o pulses with done_o and flags_o = {result bit 63, result==0, C, V}, where C and V are taken from flags_i at start. Otherwise flags_wr_o stays 0 and flags_o equals flags_i as sampled at start.
- R7: If instruction bits 27:23 differ from 00001, or bits 7:4 differ from 1001, illegal_o is 1 along with done_o and neither wr_en_o nor flags_wr_o pulses.
- R8: A start accepted at a clock edge gives done_o high for exactly one cycle, DATA_W/STEP_W+1 edges later. busy_o is high from the accepting edge until the edge that raises done_o.
- R9: start_i is ignored while busy_o is 1. The operation in flight and its result are unaffected.
- R10: res_hi_o, res_lo_o, flags_o, illegal_o and both index outputs change only with done_o, and hold their values in between.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| instr_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | Condition of the instruction holds |
| rm_val_i | input | DATA_W | First operand value |
| rs_val_i | input | DATA_W | Second operand value |
| acc_hi_i | input | DATA_W | Upper half of the addend |
| acc_lo_i | input | DATA_W | Lower half of the addend |
| flags_i | input | 4 | Current N,Z,C,V flags |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Fixed pattern bits mismatched |
| wr_en_o | output | 1 | Register pair write pulse |
| flags_wr_o | output | 1 | Flag write pulse |
| hi_idx_o | output | 4 | Destination index for the high word |
| lo_idx_o | output | 4 | Destination index for the low word |
| res_hi_o | output | DATA_W | High result word |
| res_lo_o | output | DATA_W | Low result word |
| flags_o | output | 4 | Flag values to write |

## Verification
The bench builds the unit with DATA_W=32 and STEP_W=2. That gives sixteen iteration steps and a 17-cycle latency, so each operation has a long busy window. This makes room to drive stray starts in the middle of an operation and to hold start high across the done cycle. The narrow step also propagates carries through many partial sums. Those sums are exercised by operand extremes such as the most negative value squared, all-ones times all-ones, and accumulates that wrap past 2^64.

// File: rtl/lmac_pkg.sv
// Package: shared constants and the decoded-operation type for the
// long multiply-accumulate unit. Assumes a fixed 32-bit instruction word.
package lmac_pkg;
    localparam int INSTR_W  = 32;
    localparam int IDX_W    = 4;
    localparam int FLAG_W   = 4;
    localparam int FLAG_N   = 3;
    localparam int FLAG_Z   = 2;
    localparam int POS_SGN  = 22;
    localparam int POS_ACC  = 21;
    localparam int POS_SETF = 20;
    localparam int POS_HI   = 16;
    localparam int POS_LO   = 12;
    localparam logic [4:0] CLASS_PAT = 5'b00001;
    localparam logic [3:0] MARK_PAT  = 4'b1001;

    typedef struct packed {
        logic             is_signed;
        logic             accumulate;
        logic             set_flags;
        logic             illegal;
        logic [IDX_W-1:0] hi_idx;
        logic [IDX_W-1:0] lo_idx;
    } lmac_op_t;
endpackage

// File: rtl/lmac_decode.sv
// Decoder: pulls the mode bits and destination indices out of the
// instruction word and flags a mismatch in the fixed pattern fields.
// Purely combinational; assumes the word is held stable while sampled.
module lmac_decode
    import lmac_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output lmac_op_t           op_o
);
    // Field extraction and pattern check (R4, R7).
    always_comb begin
        op_o.is_signed  = instr_i[POS_SGN];
        op_o.accumulate = instr_i[POS_ACC];
        op_o.set_flags  = instr_i[POS_SETF];
        op_o.hi_idx     = instr_i[POS_HI +: IDX_W];
        op_o.lo_idx     = instr_i[POS_LO +: IDX_W];
        op_o.illegal    = (instr_i[27:23] != CLASS_PAT) || (instr_i[7:4] != MARK_PAT);
    end
endmodule

// File: rtl/lmac_itermul.sv
// Iterative unsigned multiplier: retires STEP_W multiplier bits per cycle
// by shift-and-add into a 2*DATA_W product register. Assumes DATA_W is a
// multiple of STEP_W and that load_i is not raised while a run is active.
module lmac_itermul #(
    parameter int DATA_W = 32,
    parameter int STEP_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [DATA_W-1:0]   mcand_i,
    input  logic [DATA_W-1:0]   mplier_i,
    output logic                done_o,
    output logic [2*DATA_W-1:0] prod_o
);
    localparam int ITER  = DATA_W / STEP_W;
    localparam int CNT_W = $clog2(ITER + 1);
    localparam int SUM_W = DATA_W + STEP_W;

    logic [2*DATA_W-1:0] prod_q;
    logic [DATA_W-1:0]   mcand_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                run_q;
    logic                done_q;
    logic [SUM_W-1:0]    pp [STEP_W];
    logic [SUM_W-1:0]    sum;
    logic [2*DATA_W-1:0] prod_next;

    // One shifted copy of the multiplicand per digit bit.
    for (genvar j = 0; j < STEP_W; j++) begin : g_pp
        assign pp[j] = prod_q[j] ? (SUM_W'(mcand_q) << j) : '0;
    end

    // Add the partial products to the upper half, then shift right by STEP_W.
    always_comb begin
        sum = SUM_W'(prod_q[2*DATA_W-1:DATA_W]);
        for (int j = 0; j < STEP_W; j++) begin
            sum = sum + pp[j];
        end
        prod_next = {sum, prod_q[DATA_W-1:STEP_W]};
    end

    // Step sequencing and product register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (load_i) begin
            prod_q  <= {{DATA_W{1'b0}}, mplier_i};
            mcand_q <= mcand_i;
            cnt_q   <= '0;
            run_q   <= 1'b1;
            done_q  <= 1'b0;
        end else if (run_q) begin
            prod_q <= prod_next;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ITER - 1)) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign prod_o = prod_q;
endmodule

// File: rtl/lmac_finish.sv
// Finisher: applies the sign correction to the magnitude product, adds the
// optional addend modulo 2^(2*DATA_W), and forms the next flag values.
// Combinational; inputs are expected to be held by the caller.
module lmac_finish
    import lmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] mag_i,
    input  logic                negate_i,
    input  logic                accumulate_i,
    input  logic [2*DATA_W-1:0] addend_i,
    input  logic [FLAG_W-1:0]   flags_i,
    output logic [2*DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0]   flags_o
);
    logic [2*DATA_W-1:0] signed_prod;

    // Sign fix (R2) then wrapping accumulate (R3).
    always_comb begin
        signed_prod = negate_i ? (~mag_i + 1'b1) : mag_i;
        result_o    = accumulate_i ? (signed_prod + addend_i) : signed_prod;
    end

    // N from the top bit, Z from the full width, C and V passed on (R6).
    always_comb begin
        flags_o         = flags_i;
        flags_o[FLAG_N] = result_o[2*DATA_W-1];
        flags_o[FLAG_Z] = (result_o == '0);
    end
endmodule

// File: rtl/lmac_unit.sv
// Top: long multiply-accumulate unit. Captures instruction, operands,
// addend and flags on an accepted start, runs the iterative multiplier,
// then registers the result with a one-cycle done pulse. Assumes the
// caller supplies the condition verdict and ignores outputs until done.
module lmac_unit
    import lmac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STEP_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic                 cond_pass_i,
    input  logic [DATA_W-1:0]    rm_val_i,
    input  logic [DATA_W-1:0]    rs_val_i,
    input  logic [DATA_W-1:0]    acc_hi_i,
    input  logic [DATA_W-1:0]    acc_lo_i,
    input  logic [FLAG_W-1:0]    flags_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 illegal_o,
    output logic                 wr_en_o,
    output logic                 flags_wr_o,
    output logic [IDX_W-1:0]     hi_idx_o,
    output logic [IDX_W-1:0]     lo_idx_o,
    output logic [DATA_W-1:0]    res_hi_o,
    output logic [DATA_W-1:0]    res_lo_o,
    output logic [FLAG_W-1:0]    flags_o
);
    localparam int RES_W = 2 * DATA_W;

    lmac_op_t            op_d, op_q;
    logic                accept;
    logic                busy_q;
    logic                neg_q;
    logic                cond_q;
    logic [RES_W-1:0]    addend_q;
    logic [FLAG_W-1:0]   flags_q;
    logic [DATA_W-1:0]   mag_a, mag_b;
    logic                neg_d;
    logic                core_done;
    logic [RES_W-1:0]    core_prod;
    logic [RES_W-1:0]    fin_res;
    logic [FLAG_W-1:0]   fin_flags;
    logic                commit;

    logic                done_q, ill_q, wr_q, fwr_q;
    logic [IDX_W-1:0]    hidx_q, lidx_q;
    logic [RES_W-1:0]    res_q;
    logic [FLAG_W-1:0]   fout_q;

    lmac_decode i_dec (
        .instr_i (instr_i),
        .op_o    (op_d)
    );

    assign accept = start_i && !busy_q;

    // Operand magnitudes and final sign for signed mode (R1, R2).
    always_comb begin
        mag_a = (op_d.is_signed && rm_val_i[DATA_W-1]) ? (~rm_val_i + 1'b1) : rm_val_i;
        mag_b = (op_d.is_signed && rs_val_i[DATA_W-1]) ? (~rs_val_i + 1'b1) : rs_val_i;
        neg_d = op_d.is_signed && (rm_val_i[DATA_W-1] ^ rs_val_i[DATA_W-1]);
    end

    lmac_itermul #(
        .DATA_W (DATA_W),
        .STEP_W (STEP_W)
    ) i_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .mcand_i  (mag_a),
        .mplier_i (mag_b),
        .done_o   (core_done),
        .prod_o   (core_prod)
    );

    // Capture of the per-operation context on an accepted start (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            neg_q    <= 1'b0;
            cond_q   <= 1'b0;
            addend_q <= '0;
            flags_q  <= '0;
        end else if (accept) begin
            op_q     <= op_d;
            neg_q    <= neg_d;
            cond_q   <= cond_pass_i;
            addend_q <= {acc_hi_i, acc_lo_i};
            flags_q  <= flags_i;
        end
    end

    // Busy window from accepted start to result registration (R8).
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (accept)    busy_q <= 1'b1;
        else if (core_done) busy_q <= 1'b0;
    end

    lmac_finish #(
        .DATA_W (DATA_W)
    ) i_fin (
        .mag_i        (core_prod),
        .negate_i     (neg_q),
        .accumulate_i (op_q.accumulate),
        .addend_i     (addend_q),
        .flags_i      (flags_q),
        .result_o     (fin_res),
        .flags_o      (fin_flags)
    );

    assign commit = cond_q && !op_q.illegal;

    // Result registers, updated only with the done pulse (R5, R6, R7, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            wr_q   <= 1'b0;
            fwr_q  <= 1'b0;
            hidx_q <= '0;
            lidx_q <= '0;
            res_q  <= '0;
            fout_q <= '0;
        end else if (core_done) begin
            done_q <= 1'b1;
            ill_q  <= op_q.illegal;
            wr_q   <= commit;
            fwr_q  <= commit && op_q.set_flags;
            hidx_q <= op_q.hi_idx;
            lidx_q <= op_q.lo_idx;
            res_q  <= fin_res;
            fout_q <= (commit && op_q.set_flags) ? fin_flags : flags_q;
        end else begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            fwr_q  <= 1'b0;
        end
    end

    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign illegal_o  = ill_q;
    assign wr_en_o    = wr_q;
    assign flags_wr_o = fwr_q;
    assign hi_idx_o   = hidx_q;
    assign lo_idx_o   = lidx_q;
    assign res_hi_o   = res_q[RES_W-1:DATA_W];
    assign res_lo_o   = res_q[DATA_W-1:0];
    assign flags_o    = fout_q;
endmodule

// File: rtl/lmac_checker.sv
// Checker: temporal properties on the ports of lmac_unit, attached by bind.
module lmac_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              illegal_o,
    input logic              wr_en_o,
    input logic              flags_wr_o,
    input logic [3:0]        hi_idx_o,
    input logic [3:0]        lo_idx_o,
    input logic [DATA_W-1:0] res_hi_o,
    input logic [DATA_W-1:0] res_lo_o,
    input logic [3:0]        flags_o
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));
    p_wr_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o || flags_wr_o) |-> done_o);
    p_flags_need_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_wr_o |-> wr_en_o);
    p_illegal_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !flags_wr_o));
    p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags_wr_o |-> (flags_o[2] == ({res_hi_o, res_lo_o} == '0)) && (flags_o[3] == res_hi_o[DATA_W-1]));
    p_hold_res_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(res_hi_o) && $stable(res_lo_o) && $stable(flags_o)));
    p_hold_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hi_idx_o) && $stable(lo_idx_o) && $stable(illegal_o)));
endmodule

bind lmac_unit lmac_checker #(.DATA_W(DATA_W)) i_lmac_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o),
    .wr_en_o    (wr_en_o),
    .flags_wr_o (flags_wr_o),
    .hi_idx_o   (hi_idx_o),
    .lo_idx_o   (lo_idx_o),
    .res_hi_o   (res_hi_o),
    .res_lo_o   (res_lo_o),
    .flags_o    (flags_o)
);

// File: tb/test_lmac_unit.sv
// Bench: behavioural reference model updated at each rising edge and
// compared against every output at each falling edge.
module test_lmac_unit;
    localparam int W    = 32;
    localparam int STEP = 2;
    localparam int LAT  = W / STEP + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  instr_i = '0;
    logic         cond_pass_i = 1'b0;
    logic [W-1:0] rm_val_i = '0, rs_val_i = '0, acc_hi_i = '0, acc_lo_i = '0;
    logic [3:0]   flags_i = '0;
    logic         busy_o, done_o, illegal_o, wr_en_o, flags_wr_o;
    logic [3:0]   hi_idx_o, lo_idx_o, flags_o;
    logic [W-1:0] res_hi_o, res_lo_o;

    int vectors = 0;
    int misses  = 0;
    bit checking = 1'b0;

    always #2.5 clk = ~clk;

    lmac_unit #(.DATA_W(W), .STEP_W(STEP)) i_lmac_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .cond_pass_i(cond_pass_i), .rm_val_i(rm_val_i), .rs_val_i(rs_val_i),
        .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i), .flags_i(flags_i),
        .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o),
        .wr_en_o(wr_en_o), .flags_wr_o(flags_wr_o), .hi_idx_o(hi_idx_o),
        .lo_idx_o(lo_idx_o), .res_hi_o(res_hi_o), .res_lo_o(res_lo_o),
        .flags_o(flags_o)
    );

    // Reference model state.
    int          m_cnt;
    logic [63:0] p_res, e_res;
    logic [3:0]  p_flags, e_flags, p_hidx, e_hidx, p_lidx, e_lidx;
    logic        p_ill, e_ill, p_wr, e_wr, p_fwr, e_fwr, e_done;
    string       p_tag, e_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; e_done = 0; e_wr = 0; e_fwr = 0; e_ill = 0;
            e_res = '0; e_flags = '0; e_hidx = '0; e_lidx = '0; e_tag = "R11";
        end else begin
            e_done = 0; e_wr = 0; e_fwr = 0;
            if (m_cnt == 0) begin
                if (start_i) begin
                    logic signed [63:0] sx, sy;
                    logic [63:0] pr;
                    if (instr_i[22]) begin
                        sx = $signed(rm_val_i); sy = $signed(rs_val_i);
                        pr = sx * sy;
                    end else begin
                        pr = {32'b0, rm_val_i} * {32'b0, rs_val_i};
                    end
                    if (instr_i[21]) pr = pr + {acc_hi_i, acc_lo_i};
                    p_res  = pr;
                    p_ill  = (instr_i[27:23] != 5'b00001) || (instr_i[7:4] != 4'b1001);
                    p_wr   = cond_pass_i && !p_ill;
                    p_fwr  = p_wr && instr_i[20];
                    p_flags = p_fwr ? {pr[63], pr == 64'd0, flags_i[1:0]} : flags_i;
                    p_hidx = instr_i[19:16];
                    p_lidx = instr_i[15:12];
                    p_tag  = instr_i[21] ? "R3" : (instr_i[22] ? "R2" : "R1");
                    m_cnt  = LAT;
                end
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    e_done = 1; e_res = p_res; e_ill = p_ill; e_wr = p_wr;
                    e_fwr = p_fwr; e_flags = p_flags; e_hidx = p_hidx;
                    e_lidx = p_lidx; e_tag = p_tag;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output each cycle (R10 covers held values between dones).
    always @(negedge clk) begin
        if (checking) begin
            string rt;
            rt = e_done ? e_tag : "R10";
            chk("R8", "done", 64'(done_o), 64'(e_done));
            chk("R9", "busy", 64'(busy_o), 64'(m_cnt != 0));
            chk("R5", "wr_en", 64'(wr_en_o), 64'(e_wr));
            chk("R6", "flags_wr", 64'(flags_wr_o), 64'(e_fwr));
            chk(e_done ? "R6" : "R10", "flags", 64'(flags_o), 64'(e_flags));
            chk(e_done ? "R7" : "R10", "illegal", 64'(illegal_o), 64'(e_ill));
            chk(e_done ? "R4" : "R10", "indices", 64'({hi_idx_o, lo_idx_o}), 64'({e_hidx, e_lidx}));
            chk(rt, "result", {res_hi_o, res_lo_o}, e_res);
        end
    end

    function automatic logic [31:0] mk(input logic s, input logic a, input logic f,
                                       input logic [3:0] hi, input logic [3:0] lo);
        return {4'hE, 5'b00001, s, a, f, hi, lo, 4'h2, 4'b1001, 4'h3};
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [63:0] add, input logic [3:0] fl, input logic cp, input bit wait_done);
        @(negedge clk);
        instr_i = ins; rm_val_i = a; rs_val_i = b;
        {acc_hi_i, acc_lo_i} = add; flags_i = fl; cond_pass_i = cp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // Scramble inputs after capture: result must not depend on them.
        instr_i = $urandom; rm_val_i = $urandom; rs_val_i = $urandom;
        acc_hi_i = $urandom; acc_lo_i = $urandom; flags_i = 4'($urandom); cond_pass_i = 1'($urandom);
        if (wait_done) repeat (LAT + 1) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL R8 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state of every output.
        chk("R11", "reset outputs", 64'({busy_o, done_o, illegal_o, wr_en_o, flags_wr_o, hi_idx_o, lo_idx_o, flags_o}), 64'd0);
        chk("R11", "reset result", {res_hi_o, res_lo_o}, 64'd0);
        checking = 1'b1;

        // R1: unsigned extremes, split into high and low words.
        issue(mk(0, 0, 1, 4'h5, 4'h6), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 4'b0011, 1, 1);
        issue(mk(0, 0, 0, 4'h1, 4'h2), 32'h1234_5678, 32'h9ABC_DEF0, 64'd0, 4'b1100, 1, 1);
        // R2: signed products including most negative squared and mixed signs.
        issue(mk(1, 0, 1, 4'h7, 4'h8), 32'h8000_0000, 32'h8000_0000, 64'd0, 4'b0000, 1, 1);
        issue(mk(1, 0, 1, 4'h9, 4'hA), 32'hFFFF_FFFD, 32'd7, 64'd0, 4'b0001, 1, 1);
        issue(mk(1, 0, 1, 4'hB, 4'hC), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 4'b0010, 1, 1);
        // R3: accumulate that wraps past 2^64; signed accumulate to exactly zero (R6 Z).
        issue(mk(0, 1, 1, 4'h3, 4'h4), 32'hFFFF_FFFF, 32'h2, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0000, 1, 1);
        issue(mk(1, 1, 1, 4'hD, 4'hE), 32'hFFFF_FFFB, 32'd6, 64'd30, 4'b0011, 1, 1);
        issue(mk(0, 0, 1, 4'h0, 4'hF), 32'd0, 32'h5555_5555, 64'd0, 4'b1001, 1, 1);
        // R5: condition fails, no writes, flags pass through.
        issue(mk(1, 1, 1, 4'h2, 4'h3), 32'd9, 32'd9, 64'd1, 4'b0110, 0, 1);
        // R7: bad pattern in bits 27:23 and in bits 7:4.
        issue(mk(0, 0, 1, 4'h4, 4'h5) ^ 32'h0080_0000, 32'd3, 32'd4, 64'd0, 4'b0000, 1, 1);
        issue(mk(0, 0, 1, 4'h4, 4'h5) ^ 32'h0000_0020, 32'd3, 32'd4, 64'd0, 4'b0000, 1, 1);
        // R9: stray starts in the middle of an operation are ignored.
        issue(mk(0, 0, 1, 4'h6, 4'h7), 32'd1000, 32'd1000, 64'd0, 4'b0000, 1, 0);
        repeat (3) @(negedge clk);
        instr_i = mk(1, 1, 1, 4'hF, 4'hF); rm_val_i = 32'hDEAD_BEEF; start_i = 1'b1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        repeat (LAT) @(negedge clk);
        // R8: start held high across completion gives back-to-back operations.
        @(negedge clk);
        instr_i = mk(0, 1, 0, 4'h1, 4'h9); rm_val_i = 32'd77; rs_val_i = 32'd88;
        {acc_hi_i, acc_lo_i} = 64'd5; cond_pass_i = 1'b1; start_i = 1'b1;
        repeat (2 * LAT + 2) @(negedge clk);
        start_i = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        // Mixed random operations across all modes.
        for (int i = 0; i < 40; i++) begin
            logic [31:0] ins;
            ins = mk(1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));
            if (i % 9 == 8) ins[5] = ~ins[5];
            issue(ins, $urandom, $urandom, {$urandom, $urandom}, 4'($urandom), (i % 5) != 4, 1);
        end
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule